// File: doc/BRIEF.md
# Radio Packet Common Header Inserter

This block sits on a byte-oriented packet stream that carries section payloads. It puts a 32-bit radio-application common header in front of every packet and packs the payload tightly behind it, so header and payload share beats with no gap. Control-plane and user-plane packets pass through the same instance, because they use one header layout and are never sent at the same time.

The header values for each packet come from a small side FIFO. The producer loads it once per packet, together with a 16-bit real-time control identifier, ahead of the payload. A dispatcher state machine takes one entry at each start of packet. It holds off the upstream source when no entry is waiting, and also while an overflow beat created by the 4-byte shift is being written. An output FIFO feeds the downstream stream. A static pin selects between two handshake modes: an ordinary valid/ready handshake, or a ready latency of three cycles.

Beats use big-endian byte order: byte 0 of a beat is in bits [63:56]. The `empty` field of a last beat gives the number of unused bytes at the low end of that beat. On the input side, data moves when `in_valid` and `in_ready` are both high. The source must hold its beat stable until it is taken, and `in_ready` depends on nothing driven by the source. On the output side, in zero-latency mode a beat moves when `out_valid` and `out_ready` are both high. In three-cycle mode, every cycle with `out_valid` high transfers a beat, and the sink must accept it.

Top module: `cmn_hdr_inserter`

## Requirements
- R1: The first output beat of a packet has `out_sop` set, and its bits [63:32] carry the header. The header layout is: bit 31 direction, bits 30:28 version, bits 27:24 filter index, bits 23:16 frame, bits 15:12 subframe, bits 11:6 slot, bits 5:0 symbol.
- R2: Payload bytes follow the header in their original order with no gap. Output byte 4·k+j+4 is input payload byte 4·k+j, counting bytes across the whole packet.
- R3: If the last input beat has `in_empty` of 4 or more, the output packet has the same number of beats as the input, and its last `out_empty` is `in_empty`−4. If `in_empty` is below 4, one extra beat follows with `out_empty` = `in_empty`+4, and `in_ready` is low in the cycle that beat is written.
- R4: Header entries are used one per packet, in the order they were loaded. Every output beat of a packet carries that entry's identifier on `out_rtcid`.
- R5: While no header entry is stored and the dispatcher waits for a start of packet, `in_ready` is low. This holds after reset as well.
- R6: `hdr_ready` is high after reset. It is low once HDR_DEPTH entries are stored and not yet used.
- R7: With `lat3_en` low, a beat offered with `out_valid` high and `out_ready` low stays offered, with unchanged data, in the next cycle.
- R8: With `lat3_en` high, `out_valid` is high only in a cycle where `out_ready` was high three cycles earlier.
- R9: With the output stalled, the block accepts OUT_DEPTH input beats in zero-latency mode and OUT_DEPTH−3 beats in three-cycle mode, keeping three entries spare.
- R10: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat3_en | input | 1 | Selects three-cycle ready latency on the output; held constant after reset |
| hdr_valid | input | 1 | Header entry offered |
| hdr_ready | output | 1 | Header FIFO can take an entry |
| hdr_dir | input | 1 | Data direction field |
| hdr_ver | input | 3 | Payload version field |
| hdr_filt | input | 4 | Filter index field |
| hdr_frame | input | 8 | Frame number field |
| hdr_subf | input | 4 | Subframe field |
| hdr_slot | input | 6 | Slot field |
| hdr_sym | input | 6 | Symbol field |
| hdr_rtcid | input | 16 | Real-time control identifier for the packet |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat taken this cycle if valid |
| in_data | input | DATA_W | Input payload beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | log2(DATA_W/8) | Unused low bytes in the last beat |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Sink ready (meaning depends on `lat3_en`) |
| out_data | output | DATA_W | Output beat |
| out_sop | output | 1 | First output beat |
| out_eop | output | 1 | Last output beat |
| out_empty | output | log2(DATA_W/8) | Unused low bytes in the last output beat |
| out_rtcid | output | 16 | Identifier of the packet this beat belongs to |

## Verification
The assertions assume a well-formed input stream. Whenever the dispatcher is idle and an input beat is offered, that beat carries `in_sop`, and no `in_sop` appears inside a packet. They also assume `lat3_en` changes only while reset is held. The directed tasks build every packet from a start beat through an end beat. They load the header entry before the payload, or hold the start beat while deliberately leaving the header FIFO empty. They switch latency mode only within a reset pulse. The three-cycle consumer treats every valid beat as delivered.

// File: rtl/chi_pkg.sv
package chi_pkg;
  localparam int HDR_W     = 32;
  localparam int HDR_BYTES = HDR_W / 8;
  localparam int RTC_W     = 16;

  typedef struct packed {
    logic       dir;
    logic [2:0] ver;
    logic [3:0] filt;
    logic [7:0] frame;
    logic [3:0] subf;
    logic [5:0] slot;
    logic [5:0] sym;
  } chdr_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BODY  = 2'd1,
    ST_FLUSH = 2'd2
  } disp_st_e;
endpackage

// File: rtl/chi_fifo.sv
module chi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assign rd_data = mem[rp];

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CW'(DEPTH)) || rd_en);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> count != '0);
endmodule

// File: rtl/chi_dispatch.sv
module chi_dispatch
  import chi_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          in_sop,
  input  logic                          in_eop,
  input  logic [$clog2(DATA_W/8)-1:0]   in_empty,
  input  logic                          hdr_avail,
  input  logic [HDR_W-1:0]              hdr_word,
  input  logic [RTC_W-1:0]              hdr_rtc,
  output logic                          hdr_pop,
  input  logic                          room,
  output logic                          wr_en,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          wr_sop,
  output logic                          wr_eop,
  output logic [$clog2(DATA_W/8)-1:0]   wr_empty,
  output logic [RTC_W-1:0]              wr_rtc
);
  localparam int BYTES   = DATA_W / 8;
  localparam int EMPTY_W = $clog2(BYTES);
  localparam int HI_W    = DATA_W - HDR_W;

  disp_st_e            st, st_nx;
  logic [HDR_W-1:0]    carry_q;
  logic [EMPTY_W-1:0]  flush_emp_q;
  logic [RTC_W-1:0]    rtc_q;
  logic                acc, short_tail, fits_tail;
  logic [HDR_W-1:0]    head;

  always_comb begin
    in_ready   = room && (((st == ST_IDLE) && hdr_avail) || (st == ST_BODY));
    acc        = in_valid && in_ready;
    short_tail = in_empty < EMPTY_W'(HDR_BYTES);
    fits_tail  = in_eop && !short_tail;
    head       = (st == ST_IDLE) ? hdr_word : carry_q;
    hdr_pop    = acc && (st == ST_IDLE);
    wr_en      = acc || ((st == ST_FLUSH) && room);
    wr_rtc     = (st == ST_IDLE) ? hdr_rtc : rtc_q;
    if (st == ST_FLUSH) begin
      wr_data  = {carry_q, {HI_W{1'b0}}};
      wr_sop   = 1'b0;
      wr_eop   = 1'b1;
      wr_empty = flush_emp_q;
    end else begin
      wr_data  = {head, in_data[DATA_W-1 -: HI_W]};
      wr_sop   = (st == ST_IDLE);
      wr_eop   = fits_tail;
      wr_empty = fits_tail ? (in_empty - EMPTY_W'(HDR_BYTES)) : '0;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE, ST_BODY: begin
        if (acc) begin
          if (!in_eop)        st_nx = ST_BODY;
          else if (short_tail) st_nx = ST_FLUSH;
          else                st_nx = ST_IDLE;
        end
      end
      ST_FLUSH: if (room) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      carry_q     <= '0;
      flush_emp_q <= '0;
      rtc_q       <= '0;
    end else begin
      st <= st_nx;
      if (acc) begin
        carry_q     <= in_data[HDR_W-1:0];
        flush_emp_q <= in_empty + EMPTY_W'(BYTES - HDR_BYTES);
      end
      if (hdr_pop) rtc_q <= hdr_rtc;
    end
  end

  assert_sop_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && in_valid |-> in_sop);

  assert_no_inner_sop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY) && in_valid |-> !in_sop);

  assert_flush_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLUSH) |-> !in_ready);

  assert_hdr_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && !hdr_avail |-> !in_ready);
endmodule

// File: rtl/chi_egress.sv
module chi_egress #(
  parameter int W        = 8,
  parameter int DEPTH    = 8,
  parameter int LONG_LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat3_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         room,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]       cnt;
  logic [LONG_LAT-1:0] rdy_sr;
  logic                nonempty, credit, rd_en;
  int                  reserve;

  chi_fifo #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (out_data),
    .count   (cnt)
  );

  generate
    if (LONG_LAT > 1) begin : g_sr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_sr <= '0;
        else        rdy_sr <= {rdy_sr[LONG_LAT-2:0], out_ready};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_sr <= '0;
        else        rdy_sr <= out_ready;
      end
    end
  endgenerate

  always_comb begin
    reserve   = lat3_en ? LONG_LAT : 0;
    room      = (int'(cnt) + reserve) < DEPTH;
    nonempty  = cnt != '0;
    credit    = lat3_en ? rdy_sr[LONG_LAT-1] : out_ready;
    out_valid = nonempty && (lat3_en ? rdy_sr[LONG_LAT-1] : 1'b1);
    rd_en     = out_valid && credit;
  end

  generate
    if (LONG_LAT == 3) begin : g_chk3
      assert_rl3_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lat3_en && out_valid |-> $past(out_ready, 3));
    end
  endgenerate

  assert_rl0_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lat3_en && out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_reserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat3_en |-> int'(cnt) <= DEPTH - LONG_LAT);
endmodule

// File: rtl/cmn_hdr_inserter.sv
module cmn_hdr_inserter
  import chi_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int HDR_DEPTH = 4,
  parameter int OUT_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lat3_en,
  input  logic                          hdr_valid,
  output logic                          hdr_ready,
  input  logic                          hdr_dir,
  input  logic [2:0]                    hdr_ver,
  input  logic [3:0]                    hdr_filt,
  input  logic [7:0]                    hdr_frame,
  input  logic [3:0]                    hdr_subf,
  input  logic [5:0]                    hdr_slot,
  input  logic [5:0]                    hdr_sym,
  input  logic [15:0]                   hdr_rtcid,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          in_sop,
  input  logic                          in_eop,
  input  logic [$clog2(DATA_W/8)-1:0]   in_empty,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DATA_W-1:0]             out_data,
  output logic                          out_sop,
  output logic                          out_eop,
  output logic [$clog2(DATA_W/8)-1:0]   out_empty,
  output logic [15:0]                   out_rtcid
);
  localparam int EMPTY_W = $clog2(DATA_W / 8);
  localparam int HE_W    = HDR_W + RTC_W;
  localparam int HCW     = $clog2(HDR_DEPTH + 1);
  localparam int ENT_W   = DATA_W + 2 + EMPTY_W + RTC_W;

  chdr_t             fields;
  logic [HE_W-1:0]   hq_in, hq_out;
  logic [HCW-1:0]    hq_cnt;
  logic              hq_push, hq_pop, hq_avail;

  logic              room, wr_en, wr_sop, wr_eop;
  logic [DATA_W-1:0] wr_data;
  logic [EMPTY_W-1:0] wr_empty;
  logic [RTC_W-1:0]  wr_rtc;
  logic [ENT_W-1:0]  ent_in, ent_out;

  assign fields = '{dir: hdr_dir, ver: hdr_ver, filt: hdr_filt, frame: hdr_frame,
                    subf: hdr_subf, slot: hdr_slot, sym: hdr_sym};
  assign hq_in     = {fields, hdr_rtcid};
  assign hdr_ready = hq_cnt != HCW'(HDR_DEPTH);
  assign hq_push   = hdr_valid && hdr_ready;
  assign hq_avail  = hq_cnt != '0;

  chi_fifo #(.W(HE_W), .DEPTH(HDR_DEPTH)) u_hq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hq_push),
    .wr_data (hq_in),
    .rd_en   (hq_pop),
    .rd_data (hq_out),
    .count   (hq_cnt)
  );

  chi_dispatch #(.DATA_W(DATA_W)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_empty  (in_empty),
    .hdr_avail (hq_avail),
    .hdr_word  (hq_out[RTC_W +: HDR_W]),
    .hdr_rtc   (hq_out[RTC_W-1:0]),
    .hdr_pop   (hq_pop),
    .room      (room),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_sop    (wr_sop),
    .wr_eop    (wr_eop),
    .wr_empty  (wr_empty),
    .wr_rtc    (wr_rtc)
  );

  assign ent_in = {wr_data, wr_sop, wr_eop, wr_empty, wr_rtc};

  chi_egress #(.W(ENT_W), .DEPTH(OUT_DEPTH), .LONG_LAT(3)) u_egr (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat3_en   (lat3_en),
    .wr_en     (wr_en),
    .wr_data   (ent_in),
    .room      (room),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (ent_out)
  );

  assign {out_data, out_sop, out_eop, out_empty, out_rtcid} = ent_out;

  assert_hdr_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hq_avail);
endmodule

// File: tb/sim_cmn_hdr_inserter.sv
`timescale 1ns/1ps
module sim_cmn_hdr_inserter;
  localparam int DW = 64, BYTES = 8, OUT_DEPTH = 8, HDR_DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, lat3_en = 1'b0;
  logic hdr_valid = 1'b0, hdr_ready;
  logic hdr_dir = 1'b0; logic [2:0] hdr_ver = '0; logic [3:0] hdr_filt = '0;
  logic [7:0] hdr_frame = '0; logic [3:0] hdr_subf = '0; logic [5:0] hdr_slot = '0;
  logic [5:0] hdr_sym = '0; logic [15:0] hdr_rtcid = '0;
  logic in_valid = 1'b0, in_ready, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0; logic [2:0] in_empty = '0;
  logic out_valid, out_ready, out_sop, out_eop;
  logic [DW-1:0] out_data; logic [2:0] out_empty; logic [15:0] out_rtcid;

  cmn_hdr_inserter u0 (
    .clk(clk), .rst_n(rst_n), .lat3_en(lat3_en),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_dir(hdr_dir), .hdr_ver(hdr_ver),
    .hdr_filt(hdr_filt), .hdr_frame(hdr_frame), .hdr_subf(hdr_subf), .hdr_slot(hdr_slot),
    .hdr_sym(hdr_sym), .hdr_rtcid(hdr_rtcid),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_empty(out_empty), .out_rtcid(out_rtcid));

  int checks = 0, fails = 0, acc_cnt = 0, rmode = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] d; logic sop; logic eop; logic [2:0] emp; logic [15:0] rtc;
  } beat_t;
  beat_t expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Sink ready driver
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      case (rmode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'($urandom_range(0, 1));
        default: out_ready = 1'b0;
      endcase
    end
  end

  // Output monitor and scoreboard
  logic h1 = 0, h2 = 0, h3 = 0, stall_prev = 0;
  logic [63:0] prev_d = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; stall_prev = 0;
    end else begin
      if (lat3_en && out_valid) chk(h3 == 1'b1, "R8", "valid without ready 3 cycles before", 64'(h3), 64'd1);
      if (!lat3_en && stall_prev) chk(out_valid && out_data == prev_d, "R7", "stalled beat not held", out_data, prev_d);
      if (out_valid && (lat3_en || out_ready)) begin
        if (expq.size() == 0) chk(1'b0, "R4", "unexpected beat", out_data, '0);
        else begin
          beat_t e; logic [63:0] m;
          e = expq.pop_front();
          m = '0;
          for (int i = 0; i < BYTES; i++)
            if (!e.eop || i < BYTES - int'(e.emp)) m[63-8*i -: 8] = 8'hFF;
          chk((out_data & m) == (e.d & m), e.sop ? "R1" : "R2", "beat data", out_data & m, e.d & m);
          chk({out_sop, out_eop, out_empty} == {e.sop, e.eop, e.emp}, "R3", "sop/eop/empty",
              64'({out_sop, out_eop, out_empty}), 64'({e.sop, e.eop, e.emp}));
          chk(out_rtcid == e.rtc, "R4", "rtcid", 64'(out_rtcid), 64'(e.rtc));
        end
      end
      stall_prev = out_valid && !out_ready;
      prev_d = out_data;
      h3 = h2; h2 = h1; h1 = out_ready;
    end
  end

  task automatic do_reset(input bit l3);
    rst_n = 1'b0; lat3_en = l3; rmode = 0;
    in_valid = 0; hdr_valid = 0;
    repeat (4) @(posedge clk);
    #1; rst_n = 1'b1;
    expq.delete();
    @(posedge clk); #1;
  endtask

  task automatic push_hdr(input logic [31:0] w, input logic [15:0] r);
    bit ok;
    hdr_valid = 1'b1;
    {hdr_dir, hdr_ver, hdr_filt, hdr_frame, hdr_subf, hdr_slot, hdr_sym} = w;
    hdr_rtcid = r;
    do begin @(negedge clk); ok = hdr_ready; @(posedge clk); #1; end while (!ok);
    hdr_valid = 1'b0;
  endtask

  task automatic send_pkt(input int nb, input int emp, input logic [31:0] w, input logic [15:0] r);
    logic [63:0] pl[];
    logic [7:0] q[$];
    int nout, vb;
    bit ok;
    pl = new[nb];
    for (int b = 0; b < nb; b++) pl[b] = {$urandom, $urandom};
    for (int i = 0; i < 4; i++) q.push_back(w[31-8*i -: 8]);
    for (int b = 0; b < nb; b++) begin
      vb = (b == nb - 1) ? BYTES - emp : BYTES;
      for (int i = 0; i < vb; i++) q.push_back(pl[b][63-8*i -: 8]);
    end
    nout = (q.size() + BYTES - 1) / BYTES;
    for (int o = 0; o < nout; o++) begin
      beat_t e;
      e.d = '0;
      for (int i = 0; i < BYTES; i++)
        if (o * BYTES + i < q.size()) e.d[63-8*i -: 8] = q[o * BYTES + i];
      e.sop = (o == 0); e.eop = (o == nout - 1);
      e.emp = e.eop ? 3'(nout * BYTES - q.size()) : 3'd0;
      e.rtc = r;
      expq.push_back(e);
    end
    for (int b = 0; b < nb; b++) begin
      in_valid = 1'b1; in_data = pl[b];
      in_sop = (b == 0); in_eop = (b == nb - 1);
      in_empty = (b == nb - 1) ? 3'(emp) : 3'd0;
      do begin @(negedge clk); ok = in_ready; @(posedge clk); #1; end while (!ok);
      acc_cnt++;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (expq.size() != 0 && t < 3000) begin @(posedge clk); t++; end
    #1;
    chk(expq.size() == 0, "R4", "beats missing after drain", 64'(expq.size()), 64'd0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(hdr_ready == 1'b1, "R6", "hdr_ready after reset", 64'(hdr_ready), 64'd1);
    chk(in_ready == 1'b0, "R5", "in_ready with no header", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
  endtask

  task automatic t_basic();
    rmode = 0;
    push_hdr(32'hA5C3_1234, 16'h0101);
    push_hdr(32'h7F00_FFC0, 16'h0202);
    push_hdr(32'h0123_4567, 16'h0303);
    send_pkt(3, 5, 32'hA5C3_1234, 16'h0101);   // R3 fits: empty 5 -> 1
    send_pkt(2, 4, 32'h7F00_FFC0, 16'h0202);   // R3 boundary: empty 4 -> 0
    send_pkt(1, 6, 32'h0123_4567, 16'h0303);   // R1 single beat
    drain();
  endtask

  task automatic t_flush();
    rmode = 0;
    push_hdr(32'h8000_0001, 16'h1111);
    push_hdr(32'h4000_0002, 16'h2222);
    push_hdr(32'h2000_0003, 16'h3333);
    send_pkt(2, 3, 32'h8000_0001, 16'h1111);   // R3 extra beat, empty 7
    @(negedge clk);
    chk(in_ready == 1'b0, "R3", "in_ready during extra beat", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R3", "in_ready after extra beat", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    send_pkt(1, 0, 32'h4000_0002, 16'h2222);   // R3 full single beat -> two beats, empty 4
    send_pkt(4, 2, 32'h2000_0003, 16'h3333);
    drain();
  endtask

  task automatic t_hdr_wait();
    rmode = 0;
    fork
      send_pkt(2, 4, 32'h1357_9BDF, 16'h4444);
      begin
        repeat (5) begin
          @(negedge clk);
          chk(in_ready == 1'b0, "R5", "in_ready while header missing", 64'(in_ready), 64'd0);
        end
        @(posedge clk); #1;
        push_hdr(32'h1357_9BDF, 16'h4444);
      end
    join
    drain();
  endtask

  task automatic t_hdr_full();
    logic [31:0] w[4];
    rmode = 0;
    for (int i = 0; i < HDR_DEPTH; i++) begin
      w[i] = $urandom;
      push_hdr(w[i], 16'(16'h5000 + i));
    end
    @(negedge clk);
    chk(hdr_ready == 1'b0, "R6", "hdr_ready with FIFO full", 64'(hdr_ready), 64'd0);
    @(posedge clk); #1;
    for (int i = 0; i < HDR_DEPTH; i++) send_pkt(1 + i, (i * 3) % 8, w[i], 16'(16'h5000 + i));
    drain();
  endtask

  task automatic t_random_sink();
    rmode = 1;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w; logic [15:0] r;
      w = $urandom; r = 16'($urandom);
      push_hdr(w, r);
      send_pkt(1 + (k % 5), k % 8, w, r);
    end
    drain();
    rmode = 0;
  endtask

  task automatic t_capacity(input int expect_n);
    rmode = 2;
    repeat (4) @(posedge clk); #1;
    push_hdr(32'hC0FF_EE00, 16'h6666);
    acc_cnt = 0;
    fork
      send_pkt(20, 1, 32'hC0FF_EE00, 16'h6666);
      begin
        repeat (40) @(negedge clk);
        chk(acc_cnt == expect_n, "R9", "beats accepted while stalled", 64'(acc_cnt), 64'(expect_n));
        rmode = 0;
      end
    join
    drain();
  endtask

  initial begin
    do_reset(1'b0);
    t_reset_state();
    t_basic();
    t_flush();
    t_hdr_wait();
    t_hdr_full();
    t_random_sink();
    t_capacity(OUT_DEPTH);
    do_reset(1'b1);
    t_reset_state();
    t_basic();
    t_flush();
    t_random_sink();
    t_capacity(OUT_DEPTH - 3);
    repeat (5) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule